// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block brings the supply of a removable card socket up or down in a fixed order. A single-cycle enable request starts a full cycle. The socket supply is first forced to 0 V and allowed to drain completely. Vcc is then applied and given time to rise and settle. After that the card reset line is pulsed, and after a last settling interval the socket is reported ready. A single-cycle disable request removes power and waits for the supply to fall. A disable request may arrive part-way through an enable sequence; it abandons that sequence at once.

All intervals are counted in ticks of a one-microsecond strobe, `tick_us`, rather than in clock cycles, so the timing does not depend on the system clock frequency. Each interval is a parameter. The defaults are:

| Interval | Default |
|---|---|
| Drain | 20 ms |
| Fall | 300 ms |
| Off time | 100 ms |
| Rise | 100 ms |
| Setup | 20 ms |
| Margin | 300 ms |
| Reset pulse | 10 µs |
| Post-reset | 20 ms |

A testbench can shrink all of these. The countdown register is sized for the longest combined wait.

Top module: `sock_pwr_seq`

## Requirements
- R1: After reset, `vcc_sel` and `vpp_sel` are 2'b00, and `card_rst`, `busy` and `ready` are all low.
- R2: An accepted enable request drives `vcc_sel` to 2'b00 (0 V) in the next cycle, even when the socket was already powered. It keeps that value for the drain, fall and off-time intervals combined, counted in ticks.
- R3: `vcc_sel` then becomes 2'b01 (5 V) with `vpp_sel` at 2'b00, and `card_rst` stays low for the rise, setup and margin intervals combined.
- R4: `card_rst` is then high for the reset-pulse interval, with `vcc_sel` held at 2'b01, and then returns low.
- R5: After the post-reset interval, `busy` falls and `ready` rises in the same cycle, and `vcc_sel` stays at 2'b01.
- R6: An accepted disable request drives `vcc_sel` to 2'b00 and `ready` low in the next cycle. `busy` stays high for the drain and fall intervals combined, then falls.
- R7: A disable request during any enable interval aborts it. In the next cycle `vcc_sel` is 2'b00, `card_rst` is low, and the full power-down wait begins.
- R8: An enable request is ignored while `busy` is high. A disable request is ignored while a power-down wait is running.
- R9: When enable and disable requests arrive in the same cycle, the disable request wins.
- R10: Intervals advance only on cycles in which `tick_us` is high. Without ticks, all outputs hold.
- R11: `vpp_sel` is 2'b00 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe marking one microsecond |
| en_req | input | 1 | Power-up request pulse |
| dis_req | input | 1 | Power-down request pulse |
| vcc_sel | output | 2 | Vcc select: 00 = 0 V, 01 = 5 V |
| vpp_sel | output | 2 | Vpp select: 00 = 0 V |
| card_rst | output | 1 | Active-high card reset |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | The last enable sequence completed |

## Verification
The bench targets these corner cases:

- **Re-enable of a powered socket.** A design that skipped the power-off would leave `vcc_sel` at 01.
- **Disables landing mid-ramp and mid-reset-pulse.** A design that finished the current interval first would keep Vcc or reset asserted.
- **Simultaneous enable and disable.** A wrong priority would start a power-up instead of a power-down.
- **Requests arriving while busy.** A design that did not ignore them would restart its countdown and stretch `busy`.
- **Long stretches with no tick.** These show whether any interval advances on clock cycles instead of ticks.

A cycle-by-cycle reference model compares every output on every clock. A miscounted interval boundary therefore shows up at the exact cycle where the transition moves.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam logic [1:0] VCC_OFF = 2'b00;
    localparam logic [1:0] VCC_5V  = 2'b01;
    localparam logic [1:0] VPP_OFF = 2'b00;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_EN_DRAIN = 3'd1,
        PH_EN_FALL  = 3'd2,
        PH_RAMP     = 3'd3,
        PH_RESET    = 3'd4,
        PH_POST     = 3'd5,
        PH_DN_DRAIN = 3'd6,
        PH_DN_FALL  = 3'd7
    } phase_e;

    function automatic logic phase_is_up(phase_e ph);
        return (ph == PH_EN_DRAIN) || (ph == PH_EN_FALL) || (ph == PH_RAMP) ||
               (ph == PH_RESET) || (ph == PH_POST);
    endfunction

    function automatic logic phase_is_down(phase_e ph);
        return (ph == PH_DN_DRAIN) || (ph == PH_DN_FALL);
    endfunction

endpackage

// File: rtl/sps_timer.sv
module sps_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && (s_q.cnt == ONE);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = load_val;
        end else if (tick && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(s_q.cnt));

endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
    import sps_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LEN_DRAIN = 2,
    parameter int LEN_EFALL = 2,
    parameter int LEN_RAMP  = 2,
    parameter int LEN_RST   = 2,
    parameter int LEN_POST  = 2,
    parameter int LEN_DFALL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic             expire,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output phase_e           phase,
    output logic             ready_st
);

    typedef struct packed {
        phase_e ph;
        logic   rdy;
    } ctl_s;

    ctl_s s_d, s_q;

    function automatic logic [CNT_W-1:0] len_of(phase_e ph);
        case (ph)
            PH_EN_DRAIN, PH_DN_DRAIN: return CNT_W'(LEN_DRAIN);
            PH_EN_FALL:               return CNT_W'(LEN_EFALL);
            PH_RAMP:                  return CNT_W'(LEN_RAMP);
            PH_RESET:                 return CNT_W'(LEN_RST);
            PH_POST:                  return CNT_W'(LEN_POST);
            PH_DN_FALL:               return CNT_W'(LEN_DFALL);
            default:                  return '0;
        endcase
    endfunction

    function automatic phase_e succ(phase_e ph);
        case (ph)
            PH_EN_DRAIN: return PH_EN_FALL;
            PH_EN_FALL:  return PH_RAMP;
            PH_RAMP:     return PH_RESET;
            PH_RESET:    return PH_POST;
            PH_DN_DRAIN: return PH_DN_FALL;
            default:     return PH_IDLE;
        endcase
    endfunction

    logic abort_up, start_up;

    always_comb begin
        abort_up = dis_req && !phase_is_down(s_q.ph);
        start_up = en_req && !dis_req && (s_q.ph == PH_IDLE);
        s_d      = s_q;
        load     = 1'b0;
        load_val = '0;
        if (abort_up) begin
            s_d.ph   = PH_DN_DRAIN;
            s_d.rdy  = 1'b0;
            load     = 1'b1;
            load_val = len_of(PH_DN_DRAIN);
        end else if (start_up) begin
            s_d.ph   = PH_EN_DRAIN;
            s_d.rdy  = 1'b0;
            load     = 1'b1;
            load_val = len_of(PH_EN_DRAIN);
        end else if (expire && (s_q.ph != PH_IDLE)) begin
            s_d.ph = succ(s_q.ph);
            if (s_q.ph == PH_POST) s_d.rdy = 1'b1;
            if (succ(s_q.ph) != PH_IDLE) begin
                load     = 1'b1;
                load_val = len_of(succ(s_q.ph));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, rdy: 1'b0};
        else        s_q <= s_d;
    end

    assign phase    = s_q.ph;
    assign ready_st = s_q.rdy;

    // R8
    en_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_is_down(s_q.ph) && !expire) |=> phase_is_down(s_q.ph));

    // R5
    rdy_after_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rdy) |-> ($past(s_q.ph) == PH_POST));

endmodule

// File: rtl/sps_drive.sv
module sps_drive
    import sps_pkg::*;
(
    input  phase_e     phase,
    input  logic       ready_st,
    output logic [1:0] vcc_sel,
    output logic [1:0] vpp_sel,
    output logic       card_rst,
    output logic       busy,
    output logic       ready
);

    logic powered;

    always_comb begin
        case (phase)
            PH_RAMP, PH_RESET, PH_POST: powered = 1'b1;
            PH_IDLE:                    powered = ready_st;
            default:                    powered = 1'b0;
        endcase
        vcc_sel  = powered ? VCC_5V : VCC_OFF;
        vpp_sel  = VPP_OFF;
        card_rst = (phase == PH_RESET);
        busy     = (phase != PH_IDLE);
        ready    = ready_st && (phase == PH_IDLE);
    end

endmodule

// File: rtl/sock_pwr_seq.sv
module sock_pwr_seq
    import sps_pkg::*;
#(
    parameter int T_DRAIN  = 20000,
    parameter int T_FALL   = 300000,
    parameter int T_OFF    = 100000,
    parameter int T_RISE   = 100000,
    parameter int T_SETUP  = 20000,
    parameter int T_MARGIN = 300000,
    parameter int T_RST    = 10,
    parameter int T_POST   = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       en_req,
    input  logic       dis_req,
    output logic [1:0] vcc_sel,
    output logic [1:0] vpp_sel,
    output logic       card_rst,
    output logic       busy,
    output logic       ready
);

    localparam int LEN_EFALL = T_FALL + T_OFF;
    localparam int LEN_RAMP  = T_RISE + T_SETUP + T_MARGIN;
    localparam int MAX_A     = (LEN_EFALL > LEN_RAMP) ? LEN_EFALL : LEN_RAMP;
    localparam int MAX_B     = (T_DRAIN > T_POST) ? T_DRAIN : T_POST;
    localparam int MAX_C     = (T_FALL > T_RST) ? T_FALL : T_RST;
    localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN   = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    logic             expire, load;
    logic [CNT_W-1:0] load_val;
    phase_e           phase;
    logic             ready_st;

    sps_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

    sps_ctrl #(
        .CNT_W     (CNT_W),
        .LEN_DRAIN (T_DRAIN),
        .LEN_EFALL (LEN_EFALL),
        .LEN_RAMP  (LEN_RAMP),
        .LEN_RST   (T_RST),
        .LEN_POST  (T_POST),
        .LEN_DFALL (T_FALL)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (en_req),
        .dis_req  (dis_req),
        .expire   (expire),
        .load     (load),
        .load_val (load_val),
        .phase    (phase),
        .ready_st (ready_st)
    );

    sps_drive u_drive (
        .phase    (phase),
        .ready_st (ready_st),
        .vcc_sel  (vcc_sel),
        .vpp_sel  (vpp_sel),
        .card_rst (card_rst),
        .busy     (busy),
        .ready    (ready)
    );

    // R4
    rst_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (vcc_sel == VCC_5V));

    // R11
    vpp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_sel == VPP_OFF);

    // R7
    abort_cuts_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req && busy && vcc_sel == VCC_5V) |=> (vcc_sel == VCC_OFF && !card_rst));

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_us && !dis_req) |=> $stable({vcc_sel, card_rst, busy, ready}));

endmodule

// File: tb/sock_pwr_seq_tb.sv
module sock_pwr_seq_tb;

    localparam int P_DRAIN = 3, P_FALL = 4, P_OFF = 2;
    localparam int P_RISE = 3, P_SETUP = 2, P_MARGIN = 4;
    localparam int P_RST = 2, P_POST = 3;
    localparam int B_OFF  = P_DRAIN + P_FALL + P_OFF;
    localparam int B_RAMP = B_OFF + P_RISE + P_SETUP + P_MARGIN;
    localparam int B_RST  = B_RAMP + P_RST;
    localparam int B_UP   = B_RST + P_POST;
    localparam int B_DOWN = P_DRAIN + P_FALL;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_us = 1'b0, en_req = 1'b0, dis_req = 1'b0;
    logic [1:0] vcc_sel, vpp_sel;
    logic card_rst, busy, ready;

    int checks = 0, failures = 0, cyc = 0, tick_mode = 2, tick_ph = 0;
    int m_mode = 0, m_ticks = 0;
    bit m_rdy = 0, finished = 0;

    always #5 clk = ~clk;

    sock_pwr_seq #(
        .T_DRAIN(P_DRAIN), .T_FALL(P_FALL), .T_OFF(P_OFF), .T_RISE(P_RISE),
        .T_SETUP(P_SETUP), .T_MARGIN(P_MARGIN), .T_RST(P_RST), .T_POST(P_POST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_req(en_req),
        .dis_req(dis_req), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel),
        .card_rst(card_rst), .busy(busy), .ready(ready)
    );

    // reference model: mode 0 idle, 1 powering up, 2 powering down
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_ticks = 0; m_rdy = 0;
        end else if (m_mode != 2 && dis_req) begin
            m_mode = 2; m_ticks = 0; m_rdy = 0;
        end else if (m_mode == 0 && en_req) begin
            m_mode = 1; m_ticks = 0; m_rdy = 0;
        end else if (m_mode != 0 && tick_us) begin
            m_ticks++;
            if (m_mode == 1 && m_ticks == B_UP) begin m_mode = 0; m_rdy = 1; end
            if (m_mode == 2 && m_ticks == B_DOWN) m_mode = 0;
        end
    end

    function automatic logic [1:0] exp_vcc();
        if (m_mode == 0) return m_rdy ? 2'b01 : 2'b00;
        if (m_mode == 2) return 2'b00;
        return (m_ticks >= B_OFF) ? 2'b01 : 2'b00;
    endfunction

    function automatic logic exp_rst();
        return (m_mode == 1) && (m_ticks >= B_RAMP) && (m_ticks < B_RST);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // tick generation and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        tick_ph = (tick_ph + 1) % 3;
        tick_us <= (tick_mode == 1) || (tick_mode == 2 && tick_ph == 0);
        if (rst_n && !finished) begin
            chk(vcc_sel == exp_vcc(), "R2/R3 vcc", vcc_sel, exp_vcc());
            chk(card_rst == exp_rst(), "R4 card_rst", card_rst, exp_rst());
            chk(busy == (m_mode != 0), "R5/R6 busy", busy, m_mode != 0);
            chk(ready == (m_mode == 0 && m_rdy), "R5 ready", ready, m_rdy);
            chk(vpp_sel == 2'b00, "R11 vpp", vpp_sel, 0);
        end
        if (cyc > 100000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic pulse(input bit e, input bit d);
        @(negedge clk); en_req = e; dis_req = d;
        @(negedge clk); en_req = 1'b0; dis_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (m_mode == 0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(vcc_sel == 2'b00 && vpp_sel == 2'b00, "R1 supplies", vcc_sel, 0);
        chk(!card_rst && !busy && !ready, "R1 flags", {card_rst, busy, ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5: full power-up
        pulse(1, 0);
        chk(busy && vcc_sel == 2'b00, "R2 start", vcc_sel, 0);
        wait_idle();
        @(negedge clk);
        chk(ready && vcc_sel == 2'b01, "R5 done", ready, 1);

        // R2: re-enable of powered socket drops Vcc first
        pulse(1, 0);
        chk(vcc_sel == 2'b00, "R2 reenable", vcc_sel, 0);
        // R8: enable while busy ignored
        repeat (4) @(negedge clk);
        pulse(1, 0);
        wait_idle();

        // R6: disable from ready
        pulse(0, 1);
        chk(vcc_sel == 2'b00 && !ready && busy, "R6 off", vcc_sel, 0);
        repeat (3) @(negedge clk);
        pulse(1, 0);           // R8 ignored during power-down
        pulse(0, 1);           // R8 ignored during power-down
        wait_idle();
        @(negedge clk);
        chk(!ready && !busy && vcc_sel == 2'b00, "R8 R6 after", ready, 0);

        // R7: abort mid-ramp
        pulse(1, 0);
        while (vcc_sel != 2'b01) @(negedge clk);
        repeat (2) @(negedge clk);
        pulse(0, 1);
        chk(vcc_sel == 2'b00 && busy, "R7 ramp abort", vcc_sel, 0);
        wait_idle();

        // R7: abort during reset pulse
        pulse(1, 0);
        while (!card_rst) @(negedge clk);
        pulse(0, 1);
        chk(!card_rst && vcc_sel == 2'b00, "R7 reset abort", card_rst, 0);
        wait_idle();

        // R9: simultaneous requests
        pulse(1, 1);
        chk(busy && vcc_sel == 2'b00, "R9 busy", busy, 1);
        wait_idle();
        @(negedge clk);
        chk(!ready, "R9 not ready", ready, 0);

        // R10: no ticks, everything holds
        pulse(1, 0);
        while (vcc_sel != 2'b01) @(negedge clk);
        tick_mode = 0;
        repeat (40) @(negedge clk);
        chk(vcc_sel == 2'b01 && busy && !card_rst, "R10 hold", vcc_sel, 1);
        tick_mode = 1;
        wait_idle();
        @(negedge clk);
        chk(ready, "R10 resume", ready, 1);

        // R6: disable from idle with ticks every cycle
        pulse(0, 1);
        chk(busy && !ready, "R6 idle disable", busy, 1);
        wait_idle();
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule